// File: doc/BRIEF.md
# Drive Password Security Lock

This block guards access to a storage drive's media with a password scheme. The host presents a 256-bit password as sixteen 16-bit words and says with the first word whether it is the user or the master password. The block compares the entry against the two stored passwords, which arrive on input buses. It keeps the drive locked or unlocked and allows or aborts every incoming command according to that state.

A security level sets what the master password may do. At High level the master password can unlock the drive. At Maximum level it cannot, and only an erase request releases the lock. A scope setting decides whether the lock blocks writes only, or reads and writes together. Commands that move no data always pass.

Wrong entries are counted. After five failures every further entry is refused, correct or not, and only a hard reset lifts that lockout. Commands are classified before they reach the block. The erase operation itself is done elsewhere; this block only acknowledges the request.

Top module: `drive_sec_lock`

## Requirements
- R1: One cycle after reset is released, `locked` equals `cfg_sec_en`, `attempts_blocked` is 0, and `unlock_ok`, `unlock_fail`, `erase_done`, `cmd_done` and `cmd_abort` are all 0.
- R2: A command of class 2'b00 (non-data) or 2'b11 (other) always completes without abort, whatever the lock state.
- R3: `cmd_done` is high for one cycle, one cycle after `cmd_valid`. `cmd_abort` is set with it when the drive is locked and the class is 2'b10 (write), or when the drive is locked, the class is 2'b01 (read) and `cfg_scope`=1 (reads and writes). When `cfg_scope`=0, reads pass while the drive is locked.
- R4: A password entry is sixteen `pw_valid` beats. Beat i is compared with bits [16i+15:16i] of the selected password, and `pw_master` is sampled on beat 0. In the cycle after beat 15, exactly one of `unlock_ok` or `unlock_fail` pulses.
- R5: A matching user password unlocks the drive at either level.
- R6: A matching master password unlocks the drive when `cfg_level`=0 (High). When `cfg_level`=1 (Maximum), a master entry always fails and counts as a failure.
- R7: Each failed entry raises the failure count by one. When the count reaches 5, `attempts_blocked` goes high and stays high until reset. While it is high, every entry fails, leaves the lock unchanged and does not change the count.
- R8: `erase_req` clears the lock at either level and pulses `erase_done` one cycle later. It leaves `attempts_blocked` unchanged.
- R9: A wrong entry leaves the lock state as it was. An unfinished entry of fewer than sixteen beats produces no `unlock_ok` and no `unlock_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| cfg_sec_en | input | 1 | Security enabled; the drive comes out of reset locked |
| cfg_level | input | 1 | 0 = High level, 1 = Maximum level |
| cfg_scope | input | 1 | 0 = lock blocks writes, 1 = lock blocks reads and writes |
| user_pw | input | 256 | Stored user password |
| master_pw | input | 256 | Stored master password |
| pw_valid | input | 1 | Password word beat |
| pw_word | input | 16 | Password word |
| pw_master | input | 1 | On beat 0: the entry is the master password |
| erase_req | input | 1 | Erase request pulse |
| cmd_valid | input | 1 | Command presented |
| cmd_class | input | 2 | 00 non-data, 01 read, 10 write, 11 other |
| cmd_done | output | 1 | Command verdict valid |
| cmd_abort | output | 1 | Command rejected |
| locked | output | 1 | Drive locked |
| unlock_ok | output | 1 | Entry accepted (pulse) |
| unlock_fail | output | 1 | Entry refused (pulse) |
| erase_done | output | 1 | Erase acknowledged (pulse) |
| attempts_blocked | output | 1 | Failure limit reached |

## Verification
The assertions check on every cycle that non-data commands never abort and that a locked write always aborts. They also check that the lockout, once set, never clears and that the failure count only ever steps up by one. Finally they check that the lock falls only together with an accepted entry or an erase, that nothing unlocks while entries are blocked, and that a master entry at Maximum level never unlocks. Only the bench scenarios can show the rest: per-word comparison against the right password half, the count reaching exactly five, read gating under each scope, and that erase leaves the lockout in place.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;

    localparam int DEF_WORD_W        = 16;
    localparam int DEF_WORDS         = 16;
    localparam int DEF_ATTEMPT_LIMIT = 5;

    typedef enum logic [1:0] {
        CMD_NODATA = 2'b00,
        CMD_READ   = 2'b01,
        CMD_WRITE  = 2'b10,
        CMD_OTHER  = 2'b11
    } cmd_class_e;

    typedef enum logic {
        LVL_HIGH = 1'b0,
        LVL_MAX  = 1'b1
    } sec_level_e;

    typedef enum logic {
        SCOPE_WR   = 1'b0,
        SCOPE_RDWR = 1'b1
    } lock_scope_e;

    typedef struct packed {
        logic done;
        logic match;
        logic master;
    } pw_result_t;

    function automatic logic cmd_rejected(cmd_class_e cls, lock_scope_e scope, logic is_locked);
        return is_locked && ((cls == CMD_WRITE) || (cls == CMD_READ && scope == SCOPE_RDWR));
    endfunction

    function automatic logic master_may_unlock(sec_level_e lvl);
        return lvl == LVL_HIGH;
    endfunction

endpackage

// File: rtl/sec_pw_compare.sv
module sec_pw_compare
    import sec_lock_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int WORDS  = DEF_WORDS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pw_valid,
    input  logic [WORD_W-1:0]        pw_word,
    input  logic                     pw_master,
    input  logic [WORD_W*WORDS-1:0]  user_pw,
    input  logic [WORD_W*WORDS-1:0]  master_pw,
    output pw_result_t               res
);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic [IDX_W-1:0]  idx;
    logic              mismatch;
    logic              sel_master;
    logic              first_beat;
    logic              last_beat;
    logic              cur_master;
    logic [WORD_W-1:0] exp_word;
    logic              word_bad;

    always_comb begin
        first_beat = (idx == '0);
        last_beat  = (idx == LAST_IDX);
        cur_master = first_beat ? pw_master : sel_master;
        exp_word   = cur_master ? master_pw[int'(idx)*WORD_W +: WORD_W]
                                : user_pw[int'(idx)*WORD_W +: WORD_W];
        word_bad   = (pw_word != exp_word);
        res.done   = pw_valid && last_beat;
        res.match  = !(mismatch || word_bad);
        res.master = cur_master;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx        <= '0;
            mismatch   <= 1'b0;
            sel_master <= 1'b0;
        end else if (pw_valid) begin
            if (first_beat) sel_master <= pw_master;
            if (last_beat) begin
                idx      <= '0;
                mismatch <= 1'b0;
            end else begin
                idx      <= idx + 1'b1;
                mismatch <= mismatch || word_bad;
            end
        end
    end

    // R4: the beat index only advances on a beat
    a_r4_idx_holds: assert property (@(posedge clk) disable iff (rst)
        !pw_valid |=> $stable(idx));

endmodule

// File: rtl/sec_attempt_limiter.sv
module sec_attempt_limiter
    import sec_lock_pkg::*;
#(
    parameter int LIMIT = DEF_ATTEMPT_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_evt,
    output logic blocked
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    assign blocked = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (fail_evt && !blocked) cnt <= cnt + 1'b1;
    end

    a_r7_lockout_sticky: assert property (@(posedge clk) disable iff (rst)
        blocked |=> blocked);

    a_r7_count_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/sec_cmd_gate.sv
module sec_cmd_gate
    import sec_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_class,
    input  logic       scope,
    input  logic       is_locked,
    output logic       cmd_done,
    output logic       cmd_abort
);
    logic reject;

    assign reject = cmd_rejected(cmd_class_e'(cmd_class), lock_scope_e'(scope), is_locked);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_done  <= 1'b0;
            cmd_abort <= 1'b0;
        end else begin
            cmd_done  <= cmd_valid;
            cmd_abort <= cmd_valid && reject;
        end
    end

    a_r2_nodata_passes: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_class == CMD_NODATA || cmd_class == CMD_OTHER) |=> !cmd_abort);

    a_r3_locked_write_aborts: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_class == CMD_WRITE && is_locked |=> cmd_done && cmd_abort);

endmodule

// File: rtl/drive_sec_lock.sv
module drive_sec_lock
    import sec_lock_pkg::*;
#(
    parameter int WORD_W        = DEF_WORD_W,
    parameter int WORDS         = DEF_WORDS,
    parameter int ATTEMPT_LIMIT = DEF_ATTEMPT_LIMIT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_sec_en,
    input  logic                    cfg_level,
    input  logic                    cfg_scope,
    input  logic [WORD_W*WORDS-1:0] user_pw,
    input  logic [WORD_W*WORDS-1:0] master_pw,
    input  logic                    pw_valid,
    input  logic [WORD_W-1:0]       pw_word,
    input  logic                    pw_master,
    input  logic                    erase_req,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_class,
    output logic                    cmd_done,
    output logic                    cmd_abort,
    output logic                    locked,
    output logic                    unlock_ok,
    output logic                    unlock_fail,
    output logic                    erase_done,
    output logic                    attempts_blocked
);
    pw_result_t res;
    logic       grant;
    logic       fail_evt;

    sec_pw_compare #(.WORD_W(WORD_W), .WORDS(WORDS)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .pw_valid  (pw_valid),
        .pw_word   (pw_word),
        .pw_master (pw_master),
        .user_pw   (user_pw),
        .master_pw (master_pw),
        .res       (res)
    );

    sec_attempt_limiter #(.LIMIT(ATTEMPT_LIMIT)) u_lim (
        .clk      (clk),
        .rst      (rst),
        .fail_evt (fail_evt),
        .blocked  (attempts_blocked)
    );

    sec_cmd_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_class (cmd_class),
        .scope     (cfg_scope),
        .is_locked (locked),
        .cmd_done  (cmd_done),
        .cmd_abort (cmd_abort)
    );

    always_comb begin
        grant = res.done && res.match && !attempts_blocked &&
                (!res.master || master_may_unlock(sec_level_e'(cfg_level)));
        fail_evt = res.done && !grant;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked      <= cfg_sec_en;
            unlock_ok   <= 1'b0;
            unlock_fail <= 1'b0;
            erase_done  <= 1'b0;
        end else begin
            unlock_ok   <= grant;
            unlock_fail <= fail_evt;
            erase_done  <= erase_req;
            if (grant || erase_req) locked <= 1'b0;
        end
    end

    a_r6_max_master_denied: assert property (@(posedge clk) disable iff (rst)
        res.done && res.master && cfg_level == LVL_MAX |=> !unlock_ok && unlock_fail);

    a_r7_no_unlock_when_blocked: assert property (@(posedge clk) disable iff (rst)
        attempts_blocked |=> !unlock_ok);

    a_r8_release_has_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> unlock_ok || erase_done);

    a_r4_single_verdict: assert property (@(posedge clk) disable iff (rst)
        !(unlock_ok && unlock_fail));

endmodule

// File: tb/test_drive_sec_lock.sv
module test_drive_sec_lock;
    localparam int SEED = 1234;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_sec_en = 1'b1, cfg_level = 1'b0, cfg_scope = 1'b0;
    logic [255:0] user_pw = '0, master_pw = '0;
    logic         pw_valid = 1'b0;
    logic [15:0]  pw_word = '0;
    logic         pw_master = 1'b0;
    logic         erase_req = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_class = '0;
    logic         cmd_done, cmd_abort, locked, unlock_ok, unlock_fail, erase_done, attempts_blocked;

    int tests = 0, fails = 0;
    bit finished = 0;
    bit m_locked;
    int m_fail;

    always #5 clk = ~clk;

    drive_sec_lock i_drive_sec_lock (
        .clk(clk), .rst(rst), .cfg_sec_en(cfg_sec_en), .cfg_level(cfg_level),
        .cfg_scope(cfg_scope), .user_pw(user_pw), .master_pw(master_pw),
        .pw_valid(pw_valid), .pw_word(pw_word), .pw_master(pw_master),
        .erase_req(erase_req), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
        .cmd_done(cmd_done), .cmd_abort(cmd_abort), .locked(locked),
        .unlock_ok(unlock_ok), .unlock_fail(unlock_fail), .erase_done(erase_done),
        .attempts_blocked(attempts_blocked)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_abort(logic [1:0] cls, bit lk, bit scope);
        return lk && (cls == 2'b10 || (cls == 2'b01 && scope));
    endfunction

    function automatic bit exp_grant(bit master, bit bad, int nfail, bit lvl);
        return !bad && nfail < 5 && (!master || !lvl);
    endfunction

    task automatic do_reset(bit en, bit lvl, bit scope);
        @(negedge clk);
        cfg_sec_en = en; cfg_level = lvl; cfg_scope = scope; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_locked = en; m_fail = 0;
        chk("R1", "locked", locked, en);
        chk("R1", "blocked", attempts_blocked, 0);
        chk("R1", "pulses", {unlock_ok, unlock_fail, erase_done, cmd_done, cmd_abort}, 0);
    endtask

    task automatic do_cmd(logic [1:0] cls, string req);
        cmd_valid = 1'b1; cmd_class = cls;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, "cmd_done", cmd_done, 1);
        chk(req, "cmd_abort", cmd_abort, exp_abort(cls, m_locked, cfg_scope));
    endtask

    task automatic do_attempt(bit master, bit bad, string req);
        int bad_idx;
        bit g;
        bad_idx = $urandom % 16;
        for (int i = 0; i < 16; i++) begin
            pw_valid = 1'b1;
            pw_master = (i == 0) ? master : !master;
            pw_word = master ? master_pw[i*16 +: 16] : user_pw[i*16 +: 16];
            if (bad && i == bad_idx) pw_word = pw_word ^ (16'h1 << ($urandom % 16));
            @(negedge clk);
        end
        pw_valid = 1'b0;
        g = exp_grant(master, bad, m_fail, cfg_level);
        if (g) m_locked = 0;
        else if (m_fail < 5) m_fail++;
        chk(req, "unlock_ok", unlock_ok, g);
        chk(req, "unlock_fail", unlock_fail, !g);
        chk(req, "locked", locked, m_locked);
        chk(req, "blocked", attempts_blocked, m_fail >= 5);
    endtask

    task automatic do_erase();
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        m_locked = 0;
        chk("R8", "erase_done", erase_done, 1);
        chk("R8", "locked", locked, 0);
        chk("R8", "blocked kept", attempts_blocked, m_fail >= 5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(SEED));
        for (int i = 0; i < 8; i++) begin
            user_pw[i*32 +: 32]   = $urandom;
            master_pw[i*32 +: 32] = $urandom;
        end

        // High level, write-only scope
        do_reset(1, 0, 0);
        for (int c = 0; c < 4; c++) do_cmd(2'(c), c == 1 ? "R3" : (c == 2 ? "R3" : "R2"));
        do_attempt(0, 1, "R9");
        do_attempt(1, 0, "R6");
        for (int c = 0; c < 4; c++) do_cmd(2'(c), "R3");
        // unfinished entry: no verdict
        for (int i = 0; i < 7; i++) begin
            pw_valid = 1'b1; pw_master = 0; pw_word = user_pw[i*16 +: 16];
            @(negedge clk);
            chk("R9", "partial verdict", {unlock_ok, unlock_fail}, 0);
        end
        pw_valid = 1'b0;
        @(negedge clk);
        chk("R9", "partial verdict idle", {unlock_ok, unlock_fail}, 0);

        // Maximum level, read+write scope
        do_reset(1, 1, 1);
        do_cmd(2'b01, "R3");
        do_cmd(2'b10, "R3");
        do_cmd(2'b00, "R2");
        do_attempt(1, 0, "R6");
        do_attempt(0, 0, "R5");
        do_cmd(2'b01, "R3");

        // lockout then erase
        do_reset(1, 1, 1);
        for (int k = 0; k < 5; k++) do_attempt(0, 1, "R7");
        do_attempt(0, 0, "R7");
        do_attempt(1, 0, "R7");
        do_erase();
        do_cmd(2'b10, "R8");

        // erase at High level
        do_reset(1, 0, 1);
        do_erase();

        // security disabled
        do_reset(0, 0, 1);
        for (int c = 0; c < 4; c++) do_cmd(2'(c), "R1");

        // random mix
        do_reset(1, 0, 1);
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom % 20;
            if (op == 0) do_reset($urandom % 4 != 0, 1'($urandom), 1'($urandom));
            else if (op == 1) do_erase();
            else if (op < 9) do_attempt(1'($urandom), ($urandom % 3) != 0, "R7");
            else do_cmd(2'($urandom), "R3");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule